// File: doc/BRIEF.md
# Configurable Register Macrocell

This block is one output cell of a programmable logic fabric. A sum-of-products term arrives on `sum_in`. The cell either passes the term straight through or stores it in a register. The register can act as a D-type or a T-type storage element. Its clock is picked from a set of global clock lines and two of six local control terms. Each global line can be used on its rising or its falling edge. Two control terms force the register high or low, and four others can gate the pad driver. A global active-low three-state pin overrides every local enable. Two feedback values go back into the routing: one taken ahead of the pad driver and one taken from the pad itself.

The cell runs on one system clock, `clk`. All clock sources are sampled on its rising edge. A qualifying transition on the selected source, seen between two system edges, updates the register on the next system edge. Preset and reset are level-driven. They are sampled on the same edge, take priority over any clocked update, and hold the register for as long as they are asserted.

The register is a two-state machine with the states Q_LOW and Q_HIGH. Each system edge applies one of five transitions:
- CLEAR: reset term active.
- SET: preset term active.
- LOAD: D-mode clock event.
- TOGGLE: T-mode clock event with `sum_in` = 1.
- HOLD: anything else.

Top module: `mcell_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, the register holds 0 until the first event that changes it.
- R2: With `cfg_mode` = 1 (D), each selected clock event loads `sum_in` into the register. The result is visible on `mc_fb` after the system edge that samples the event.
- R3: With `cfg_mode` = 2 (T), each selected clock event inverts the register when `sum_in` is 1 and leaves it unchanged when `sum_in` is 0.
- R4: With `cfg_mode` = 0 or 3 (combinational), `mc_fb` equals `sum_in` in the same cycle, independent of any clock.
- R5: `cfg_clk_sel` codes 0 to 3 select `gclk[0]` to `gclk[3]`, code 4 selects `ct[2]` and code 5 selects `ct[3]`. Codes 6 and 7 select no source, and the register keeps its value.
- R6: With `cfg_clk_fall` = 1, a global clock event is a 1-to-0 transition; otherwise it is a 0-to-1 transition. Control-term clocks always use the 0-to-1 transition, whatever `cfg_clk_fall` is.
- R7: With `cfg_init_en` = 1, `ct[0]` high sets the register to 1 and `ct[1]` high clears it to 0, overriding clock events. With `cfg_init_en` = 0, both terms have no effect on the register.
- R8: When `ct[0]` and `ct[1]` are high together and `cfg_init_en` is 1, the register is cleared to 0.
- R9: `cfg_oe_sel` selects the local enable: 0 is off, 1 is on, and 2, 3, 4 and 5 use `ct[2]`, `ct[3]`, `ct[4]` and `ct[5]`. Codes 6 and 7 mean off.
- R10: When `gts_en` is 1 and `gts_n` is 0, `pad_oe` is 0 whatever the local enable.
- R11: `pad_out` equals `mc_fb`. `pad_fb` equals `pad_out` while `pad_oe` is 1, and equals `pad_in` while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all sources |
| rst_n | input | 1 | Active-low power-on reset |
| sum_in | input | 1 | Sum-of-products term from the array |
| gclk | input | N_GCLK | Global clock lines |
| ct | input | 6 | Local control terms |
| gts_en | input | 1 | Enables the global three-state override |
| gts_n | input | 1 | Global three-state pin, active low |
| pad_in | input | 1 | Value present on the pad when it is not driven |
| cfg_mode | input | 2 | 0 and 3 combinational, 1 D, 2 T |
| cfg_clk_sel | input | $clog2(N_GCLK+2) | Clock source select |
| cfg_clk_fall | input | 1 | Use the falling edge of global clocks |
| cfg_init_en | input | 1 | Enables preset and reset from ct[0] and ct[1] |
| cfg_oe_sel | input | 3 | Output-enable source select |
| mc_fb | output | 1 | Macrocell feedback, taken ahead of the pad driver |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Effective pad drive enable |
| pad_fb | output | 1 | Feedback taken from the pad |

## Verification
The bench builds the cell with the default of four global clocks. This gives a three-bit source select, so the two spare codes 6 and 7 can be driven, along with both control-term clocks. Random configurations change every few dozen cycles, while the global lines and control terms toggle freely. This produces rising and falling events on every source, simultaneous preset and reset, and override cases against every enable source, all compared each cycle with a behavioural model.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

    // Storage mode of the cell
    typedef enum logic [1:0] {
        MODE_COMB = 2'd0,
        MODE_DFF  = 2'd1,
        MODE_TFF  = 2'd2,
        MODE_PASS = 2'd3
    } mode_e;

    // Output-enable source
    typedef enum logic [2:0] {
        OE_OFF  = 3'd0,
        OE_ON   = 3'd1,
        OE_CT2  = 3'd2,
        OE_CT3  = 3'd3,
        OE_CT4  = 3'd4,
        OE_CT5  = 3'd5,
        OE_RSV6 = 3'd6,
        OE_RSV7 = 3'd7
    } oe_sel_e;

    // Register states
    typedef enum logic {
        Q_LOW  = 1'b0,
        Q_HIGH = 1'b1
    } qstate_e;

    // Transitions applied on a system edge
    typedef enum logic [2:0] {
        ACT_HOLD   = 3'd0,
        ACT_CLEAR  = 3'd1,
        ACT_SET    = 3'd2,
        ACT_LOAD   = 3'd3,
        ACT_TOGGLE = 3'd4
    } act_e;

    localparam int CT_COUNT  = 6;
    localparam int CT_PRESET = 0;
    localparam int CT_RESET  = 1;
    localparam int CT_CLK_LO = 2;
    localparam int CT_CLK_N  = 2;
    localparam int OE_SEL_W  = 3;

endpackage

// File: rtl/mcell_clk_pick.sv
module mcell_clk_pick #(
    parameter int N_GCLK = 4,
    parameter int N_CTCK = 2,
    parameter int SEL_W  = $clog2(N_GCLK + N_CTCK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_GCLK-1:0] gclk,
    input  logic [N_CTCK-1:0] ctclk,
    input  logic [SEL_W-1:0]  sel,
    input  logic              fall,
    output logic              tick
);

    localparam int SRC_N = N_GCLK + N_CTCK;

    logic [SRC_N-1:0] edge_hit;

    // Global lines: edge direction chosen by fall
    for (genvar g = 0; g < N_GCLK; g++) begin : g_glob
        logic prev;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev <= 1'b0;
            else        prev <= gclk[g];
        end
        assign edge_hit[g] = fall ? (prev & ~gclk[g]) : (~prev & gclk[g]);
    end

    // Control-term clocks: rising only
    for (genvar c = 0; c < N_CTCK; c++) begin : g_ctck
        logic prev;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev <= 1'b0;
            else        prev <= ctclk[c];
        end
        assign edge_hit[N_GCLK + c] = ~prev & ctclk[c];
    end

    // Codes beyond the source count pick nothing
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < SRC_N; i++) begin
            if (sel == SEL_W'(i)) tick = edge_hit[i];
        end
    end

endmodule

// File: rtl/mcell_reg_fsm.sv
module mcell_reg_fsm
    import mcell_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  mode_e mode,
    input  logic  sum_in,
    input  logic  init_en,
    input  logic  ct_preset,
    input  logic  ct_reset,
    output logic  q
);

    qstate_e state, state_nx;
    act_e    act;

    // Transition choice: reset over preset over clocked update
    always_comb begin
        if (init_en && ct_reset)
            act = ACT_CLEAR;
        else if (init_en && ct_preset)
            act = ACT_SET;
        else if (tick && mode == MODE_DFF)
            act = ACT_LOAD;
        else if (tick && mode == MODE_TFF && sum_in)
            act = ACT_TOGGLE;
        else
            act = ACT_HOLD;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            Q_LOW: begin
                case (act)
                    ACT_SET:    state_nx = Q_HIGH;
                    ACT_TOGGLE: state_nx = Q_HIGH;
                    ACT_LOAD:   state_nx = sum_in ? Q_HIGH : Q_LOW;
                    default:    state_nx = Q_LOW;
                endcase
            end
            Q_HIGH: begin
                case (act)
                    ACT_CLEAR:  state_nx = Q_LOW;
                    ACT_TOGGLE: state_nx = Q_LOW;
                    ACT_LOAD:   state_nx = sum_in ? Q_HIGH : Q_LOW;
                    default:    state_nx = Q_HIGH;
                endcase
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_LOW;
        else        state <= state_nx;
    end

    // Output decode
    always_comb begin
        unique case (state)
            Q_LOW:  q = 1'b0;
            Q_HIGH: q = 1'b1;
        endcase
    end

endmodule

// File: rtl/mcell_oe_ctl.sv
module mcell_oe_ctl
    import mcell_pkg::*;
(
    input  oe_sel_e             sel,
    input  logic [CT_COUNT-1:0] ct,
    input  logic                gts_en,
    input  logic                gts_n,
    output logic                oe
);

    logic oe_local;
    logic gts_kill;

    always_comb begin
        unique case (sel)
            OE_OFF:  oe_local = 1'b0;
            OE_ON:   oe_local = 1'b1;
            OE_CT2:  oe_local = ct[2];
            OE_CT3:  oe_local = ct[3];
            OE_CT4:  oe_local = ct[4];
            OE_CT5:  oe_local = ct[5];
            OE_RSV6: oe_local = 1'b0;
            OE_RSV7: oe_local = 1'b0;
        endcase
    end

    assign gts_kill = gts_en & ~gts_n;
    assign oe       = oe_local & ~gts_kill;

endmodule

// File: rtl/mcell_top.sv
module mcell_top
    import mcell_pkg::*;
#(
    parameter int N_GCLK = 4,
    localparam int CLK_SEL_W = $clog2(N_GCLK + CT_CLK_N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sum_in,
    input  logic [N_GCLK-1:0]    gclk,
    input  logic [CT_COUNT-1:0]  ct,
    input  logic                 gts_en,
    input  logic                 gts_n,
    input  logic                 pad_in,
    input  logic [1:0]           cfg_mode,
    input  logic [CLK_SEL_W-1:0] cfg_clk_sel,
    input  logic                 cfg_clk_fall,
    input  logic                 cfg_init_en,
    input  logic [OE_SEL_W-1:0]  cfg_oe_sel,
    output logic                 mc_fb,
    output logic                 pad_out,
    output logic                 pad_oe,
    output logic                 pad_fb
);

    mode_e mode;
    logic  tick;
    logic  reg_q;
    logic  registered;

    assign mode = mode_e'(cfg_mode);

    mcell_clk_pick #(
        .N_GCLK (N_GCLK),
        .N_CTCK (CT_CLK_N),
        .SEL_W  (CLK_SEL_W)
    ) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .gclk   (gclk),
        .ctclk  (ct[CT_CLK_LO +: CT_CLK_N]),
        .sel    (cfg_clk_sel),
        .fall   (cfg_clk_fall),
        .tick   (tick)
    );

    mcell_reg_fsm u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (mode),
        .sum_in    (sum_in),
        .init_en   (cfg_init_en),
        .ct_preset (ct[CT_PRESET]),
        .ct_reset  (ct[CT_RESET]),
        .q         (reg_q)
    );

    mcell_oe_ctl u_oe (
        .sel    (oe_sel_e'(cfg_oe_sel)),
        .ct     (ct),
        .gts_en (gts_en),
        .gts_n  (gts_n),
        .oe     (pad_oe)
    );

    // Feedback ahead of the driver, then the pad model
    assign registered = (mode == MODE_DFF) || (mode == MODE_TFF);
    assign mc_fb      = registered ? reg_q : sum_in;
    assign pad_out    = mc_fb;
    assign pad_fb     = pad_oe ? pad_out : pad_in;

endmodule

// File: rtl/mcell_chk.sv
module mcell_chk #(
    parameter int N_GCLK = 4,
    parameter int SEL_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sum_in,
    input logic [5:0]       ct,
    input logic             gts_en,
    input logic             gts_n,
    input logic             pad_in,
    input logic [1:0]       cfg_mode,
    input logic [SEL_W-1:0] cfg_clk_sel,
    input logic             cfg_init_en,
    input logic             mc_fb,
    input logic             pad_out,
    input logic             pad_oe,
    input logic             pad_fb,
    input logic             reg_q
);

    localparam logic [SEL_W-1:0] FIRST_NONE = SEL_W'(N_GCLK + 2);

    p_comb_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0 || cfg_mode == 2'd3) |-> (mc_fb == sum_in));

    p_no_source_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk_sel >= FIRST_NONE && !(cfg_init_en && (ct[0] || ct[1])))
        |=> $stable(reg_q));

    p_preset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_init_en && ct[0] && !ct[1]) |=> reg_q);

    p_reset_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_init_en && ct[1]) |=> !reg_q);

    p_gts_override_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gts_en && !gts_n) |-> !pad_oe);

    p_pad_driven_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> (pad_fb == pad_out));

    p_pad_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe |-> (pad_fb == pad_in));

endmodule

bind mcell_top mcell_chk #(
    .N_GCLK (N_GCLK),
    .SEL_W  (CLK_SEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sum_in      (sum_in),
    .ct          (ct),
    .gts_en      (gts_en),
    .gts_n       (gts_n),
    .pad_in      (pad_in),
    .cfg_mode    (cfg_mode),
    .cfg_clk_sel (cfg_clk_sel),
    .cfg_init_en (cfg_init_en),
    .mc_fb       (mc_fb),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_fb      (pad_fb),
    .reg_q       (reg_q)
);

// File: tb/tb_mcell_top.sv
`timescale 1ns/1ps
module tb_mcell_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sum_in;
    logic [3:0] gclk;
    logic [5:0] ct;
    logic       gts_en, gts_n, pad_in;
    logic [1:0] cfg_mode;
    logic [2:0] cfg_clk_sel;
    logic       cfg_clk_fall, cfg_init_en;
    logic [2:0] cfg_oe_sel;
    logic       mc_fb, pad_out, pad_oe, pad_fb;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    string tag      = "R1";

    always #2 clk = ~clk;

    mcell_top dut (
        .clk(clk), .rst_n(rst_n), .sum_in(sum_in), .gclk(gclk), .ct(ct),
        .gts_en(gts_en), .gts_n(gts_n), .pad_in(pad_in),
        .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
        .cfg_clk_fall(cfg_clk_fall), .cfg_init_en(cfg_init_en),
        .cfg_oe_sel(cfg_oe_sel),
        .mc_fb(mc_fb), .pad_out(pad_out), .pad_oe(pad_oe), .pad_fb(pad_fb)
    );

    // Behavioural reference: sampled history plus stored bit
    bit       m_q;
    bit [3:0] m_pg;
    bit       m_p2, m_p3;
    bit       m_ev;
    int       m_sel;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q = 0; m_pg = '0; m_p2 = 0; m_p3 = 0;
        end else begin
            m_sel = int'(cfg_clk_sel);
            m_ev  = 0;
            if (m_sel < 4)
                m_ev = cfg_clk_fall ? (m_pg[m_sel] && !gclk[m_sel])
                                    : (!m_pg[m_sel] && gclk[m_sel]);
            else if (m_sel == 4) m_ev = ct[2] && !m_p2;
            else if (m_sel == 5) m_ev = ct[3] && !m_p3;
            if (cfg_init_en && ct[1])      m_q = 0;
            else if (cfg_init_en && ct[0]) m_q = 1;
            else if (m_ev && cfg_mode == 2'd1) m_q = sum_in;
            else if (m_ev && cfg_mode == 2'd2 && sum_in) m_q = !m_q;
            m_pg = gclk; m_p2 = ct[2]; m_p3 = ct[3];
        end
    end

    task automatic chk1(string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic e_fb, e_loc, e_oe;
        e_fb = (cfg_mode == 2'd1 || cfg_mode == 2'd2) ? m_q : sum_in;
        case (cfg_oe_sel)
            3'd1: e_loc = 1'b1;
            3'd2: e_loc = ct[2];
            3'd3: e_loc = ct[3];
            3'd4: e_loc = ct[4];
            3'd5: e_loc = ct[5];
            default: e_loc = 1'b0;
        endcase
        e_oe = e_loc && !(gts_en && !gts_n);
        chk1("mc_fb",   mc_fb,   e_fb);
        chk1("pad_out", pad_out, e_fb);
        chk1("pad_oe",  pad_oe,  e_oe);
        chk1("pad_fb",  pad_fb,  e_oe ? e_fb : pad_in);
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_all();
        end
    endtask

    initial begin
        rst_n = 0; sum_in = 0; gclk = '0; ct = '0; gts_en = 0; gts_n = 1;
        pad_in = 0; cfg_mode = 2'd1; cfg_clk_sel = 3'd0; cfg_clk_fall = 0;
        cfg_init_en = 0; cfg_oe_sel = 3'd1;
        repeat (3) @(negedge clk);
        tag = "R1"; chk1("reset mc_fb", mc_fb, 1'b0);
        rst_n = 1;
        step(2);
        chk1("after reset mc_fb", mc_fb, 1'b0);

        // R2: D mode on rising gclk[0]
        tag = "R2";
        sum_in = 1; step(1); gclk[0] = 1; step(1);
        chk1("D load 1", mc_fb, 1'b1);
        sum_in = 0; gclk[0] = 0; step(1); gclk[0] = 1; step(1);
        chk1("D load 0", mc_fb, 1'b0);

        // R6: falling edge on gclk[1], and CT clock ignores fall
        tag = "R6";
        cfg_clk_sel = 3'd1; cfg_clk_fall = 1; sum_in = 1;
        gclk[1] = 1; step(1);
        chk1("no load on rise", mc_fb, 1'b0);
        gclk[1] = 0; step(1);
        chk1("load on fall", mc_fb, 1'b1);
        cfg_clk_sel = 3'd4; sum_in = 0; ct[2] = 1; step(1);
        chk1("ct2 rising with fall set", mc_fb, 1'b0);
        cfg_clk_fall = 0;

        // R5: every source, then the empty codes
        tag = "R5";
        for (int s = 0; s < 8; s++) begin
            cfg_clk_sel = 3'(s); gclk = '0; ct = '0; step(1);
            sum_in = ~sum_in; gclk = 4'hF; ct[3:2] = 2'b11; step(2);
        end

        // R3: toggle behaviour on gclk[2]
        tag = "R3";
        cfg_mode = 2'd2; cfg_clk_sel = 3'd2; gclk = '0; ct = '0;
        for (int k = 0; k < 6; k++) begin
            sum_in = (k != 3); gclk[2] = ~gclk[2]; step(1);
        end

        // R4: combinational modes
        tag = "R4";
        for (int md = 0; md < 4; md += 3) begin
            cfg_mode = 2'(md);
            for (int k = 0; k < 4; k++) begin sum_in = k[0]; gclk = 4'(k); step(1); end
        end

        // R7 / R8: preset, reset, disabled, both
        cfg_mode = 2'd1; cfg_clk_sel = 3'd7;
        tag = "R7"; cfg_init_en = 0; ct[0] = 1; step(2);
        ct[0] = 0; ct[1] = 1; step(2); ct[1] = 0;
        cfg_init_en = 1; ct[0] = 1; step(2); ct[0] = 0; step(1);
        ct[1] = 1; step(1); ct[1] = 0; ct[0] = 1; step(1);
        tag = "R8"; ct[1:0] = 2'b11; step(2);
        chk1("both asserted", mc_fb, 1'b0);
        ct = '0; cfg_init_en = 0;

        // R9: every enable code against every control term
        tag = "R9";
        for (int o = 0; o < 8; o++) begin
            cfg_oe_sel = 3'(o);
            for (int k = 0; k < 4; k++) begin ct[5:2] = 4'(1 << k); step(1); end
        end
        ct = '0;

        // R10: override cases
        tag = "R10";
        cfg_oe_sel = 3'd1;
        for (int k = 0; k < 4; k++) begin gts_en = k[1]; gts_n = k[0]; step(1); end
        gts_en = 1; gts_n = 0; step(1);
        chk1("forced off", pad_oe, 1'b0);
        gts_en = 0; gts_n = 1;

        // R11: pad feedback with driver on and off
        tag = "R11"; cfg_mode = 2'd0;
        for (int k = 0; k < 8; k++) begin
            cfg_oe_sel = k[2] ? 3'd0 : 3'd1; sum_in = k[0]; pad_in = k[1]; step(1);
        end

        // Random mix over all requirements
        tag = "R2 R3 R5 R6 R7 R8";
        for (int blk = 0; blk < 120; blk++) begin
            cfg_mode = 2'($urandom); cfg_clk_sel = 3'($urandom);
            cfg_clk_fall = 1'($urandom); cfg_init_en = 1'($urandom);
            cfg_oe_sel = 3'($urandom);
            for (int c = 0; c < 30; c++) begin
                sum_in = 1'($urandom); gclk = 4'($urandom);
                ct[5:2] = 4'($urandom);
                ct[1:0] = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
                gts_en = 1'($urandom); gts_n = 1'($urandom); pad_in = 1'($urandom);
                step(1);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule